// File: doc/BRIEF.md
# DSI generic command packet engine

This block turns generic command writes from a register interface into DSI short and long packet byte streams, and packs the bytes of peripheral read responses back into 32-bit words for software. Software loads any long-packet payload first, as 32-bit words, into a transmit payload queue. It then writes a 24-bit header word. Writing the header word starts the transmission. Headers wait in a command queue. The transmitter sends each packet as a byte stream toward the lane layer, with start and end markers and a valid/ready handshake.

Response bytes from the lane layer are packed little-endian into a receive queue. Software reads them through the payload read port. Status bits report whether each queue is empty and whether a read response has completed. A sticky flag records header writes that were lost because the command queue was full. ECC, CRC, bus turnaround and lane timing are handled outside this block.

Top module: `dsi_gcmd_engine`

## Requirements
- R1: The header word carries data type in bits 5:0, virtual channel (0 to 3) in bits 7:6, low byte in bits 15:8 and high byte in bits 23:16. A packet leaves as byte {vc,dt} (tx_sop high), then the low byte, then the high byte.
- R2: A data type whose low nibble is 0x9 is long. Any other type is short and ends (tx_last) on its third byte.
- R3: A long packet's word count is {high,low}. After the header it sends exactly that many payload bytes, taken from each 32-bit payload word least significant byte first. Unused bytes of the final word are discarded, and the next long packet starts on a fresh word. A zero count ends on the header.
- R4: A long packet does not start until the payload queue holds at least word-count bytes (four per stored word).
- R5: Headers with data type 0x09 (null) or 0x19 (blanking) are dropped and never transmitted.
- R6: A header write while the command queue is full is dropped and sets cmd_ovf. cmd_ovf stays set until reset.
- R7: status bit 1 = receive queue empty, bit 3 = transmit payload queue empty, bit 5 = command queue empty, bit 7 = read done. All other bits read 0. After reset status is 0x2A. A command stays in the queue until its last byte is accepted.
- R8: Response bytes are packed into 32-bit words, the earliest byte in bits 7:0. A word is stored after four bytes, or after the byte flagged rx_last, with the missing upper bytes zero. pld_rd_en pops the word shown on pld_rdata.
- R9: Read done is set by the byte flagged rx_last and cleared by the next header write.
- R10: While tx_valid is high and tx_ready low, tx_valid, tx_data, tx_sop and tx_last hold.
- R11: Accepted headers are transmitted in the order written, with no extra bytes.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| hdr_wr_en | input | 1 | Header write strobe |
| hdr_wdata | input | 24 | Header word |
| pld_wr_en | input | 1 | Transmit payload word write strobe |
| pld_wdata | input | 32 | Transmit payload word |
| pld_rd_en | input | 1 | Pop one response word |
| pld_rdata | output | 32 | Oldest response word |
| status | output | 8 | Queue empty flags and read done |
| cmd_ovf | output | 1 | Sticky command overflow flag |
| tx_valid | output | 1 | Transmit byte valid |
| tx_ready | input | 1 | Lane layer accepts the byte |
| tx_data | output | 8 | Transmit byte |
| tx_sop | output | 1 | First byte of a packet |
| tx_last | output | 1 | Last byte of a packet |
| rx_valid | input | 1 | Response byte valid |
| rx_data | input | 8 | Response byte |
| rx_last | input | 1 | Final byte of a response |

## Verification
The assertions check the following on every cycle:
- the transmit handshake holds under back-pressure;
- no null or blanking header ever leaves;
- nothing is sent while the command queue reads empty;
- the overflow flag is set by a full-queue write and then stays set;
- read done is set and cleared by its events.

Only the bench scenarios can show:
- the byte order and content of short and long packets;
- that payload words are trimmed;
- that a long packet is held back until enough payload is present;
- the little-endian packing and zero padding of responses;
- the order of packets after an overflow.

// File: rtl/dsi_gcmd_pkg.sv
package dsi_gcmd_pkg;

    // Header layout; the packed order matches bits 23:0 of the written word.
    typedef struct packed {
        logic [7:0] hi;
        logic [7:0] lo;
        logic [1:0] vc;
        logic [5:0] dt;
    } gcmd_hdr_t;

    typedef enum logic [1:0] {
        TX_IDLE,
        TX_HDR,
        TX_PLD
    } tx_state_e;

    localparam logic [5:0] DT_NULL_PKT  = 6'h09;
    localparam logic [5:0] DT_BLANK_PKT = 6'h19;

    localparam int ST_RSP_EMPTY = 1;
    localparam int ST_PLD_EMPTY = 3;
    localparam int ST_CMD_EMPTY = 5;
    localparam int ST_RD_DONE   = 7;

    function automatic logic dt_is_long(logic [5:0] dt);
        return dt[3:0] == 4'h9;
    endfunction

    function automatic logic dt_is_barred(logic [5:0] dt);
        return (dt == DT_NULL_PKT) || (dt == DT_BLANK_PKT);
    endfunction

    function automatic int level_width(int depth);
        return $clog2(depth + 1);
    endfunction

endpackage

// File: rtl/dsi_gcmd_fifo.sv
module dsi_gcmd_fifo #(
    parameter int W     = 32,
    parameter int DEPTH = 4,
    localparam int AW   = (DEPTH > 1) ? $clog2(DEPTH) : 1,
    localparam int CW   = dsi_gcmd_pkg::level_width(DEPTH)
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          push,
    input  logic [W-1:0]  wdata,
    input  logic          pop,
    output logic [W-1:0]  rdata,
    output logic [CW-1:0] count
);
    logic [W-1:0]  mem [DEPTH];
    logic [AW-1:0] wp, rp;
    logic          do_push, do_pop;

    function automatic logic [AW-1:0] step(logic [AW-1:0] p);
        return (p == AW'(DEPTH - 1)) ? '0 : p + 1'b1;
    endfunction

    assign do_push = push && (count != CW'(DEPTH));
    assign do_pop  = pop && (count != '0);
    assign rdata   = mem[rp];

    always_ff @(posedge clk) begin
        if (do_push) mem[wp] <= wdata;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            wp    <= '0;
            rp    <= '0;
            count <= '0;
        end else begin
            if (do_push) wp <= step(wp);
            if (do_pop)  rp <= step(rp);
            case ({do_push, do_pop})
                2'b10:   count <= count + 1'b1;
                2'b01:   count <= count - 1'b1;
                default: ;
            endcase
        end
    end
endmodule

// File: rtl/dsi_gcmd_tx.sv
module dsi_gcmd_tx
    import dsi_gcmd_pkg::*;
#(
    parameter int PCW = 4
) (
    input  logic           clk,
    input  logic           rst,
    input  logic           cmd_valid,
    input  gcmd_hdr_t      cmd_hdr,
    output logic           cmd_pop,
    input  logic [31:0]    pld_word,
    input  logic [PCW-1:0] pld_count,
    output logic           pld_pop,
    output logic           tx_valid,
    input  logic           tx_ready,
    output logic [7:0]     tx_data,
    output logic           tx_sop,
    output logic           tx_last
);
    tx_state_e   state;
    logic [1:0]  hidx;
    logic [1:0]  lane;
    logic [15:0] rem;
    logic [15:0] wc;
    logic        is_long, enough, accept;
    logic [31:0] avail;

    assign wc      = {cmd_hdr.hi, cmd_hdr.lo};
    assign is_long = dt_is_long(cmd_hdr.dt);
    assign avail   = 32'(pld_count) << 2;
    assign enough  = avail >= {16'd0, wc};
    assign accept  = tx_valid && tx_ready;

    always_comb begin
        tx_valid = (state != TX_IDLE);
        tx_sop   = (state == TX_HDR) && (hidx == 2'd0);
        tx_data  = 8'h00;
        tx_last  = 1'b0;
        if (state == TX_HDR) begin
            case (hidx)
                2'd0:    tx_data = {cmd_hdr.vc, cmd_hdr.dt};
                2'd1:    tx_data = cmd_hdr.lo;
                default: tx_data = cmd_hdr.hi;
            endcase
            tx_last = (hidx == 2'd2) && (!is_long || wc == 16'd0);
        end else if (state == TX_PLD) begin
            tx_data = pld_word[{lane, 3'b000} +: 8];
            tx_last = (rem == 16'd1);
        end
    end

    assign cmd_pop = accept && tx_last;
    assign pld_pop = accept && (state == TX_PLD) && (lane == 2'd3 || rem == 16'd1);

    always_ff @(posedge clk) begin
        if (rst) begin
            state <= TX_IDLE;
            hidx  <= '0;
            lane  <= '0;
            rem   <= '0;
        end else begin
            case (state)
                TX_IDLE: begin
                    if (cmd_valid && (!is_long || enough)) begin
                        state <= TX_HDR;
                        hidx  <= '0;
                    end
                end
                TX_HDR: begin
                    if (accept) begin
                        if (hidx == 2'd2) begin
                            state <= tx_last ? TX_IDLE : TX_PLD;
                            rem   <= wc;
                            lane  <= '0;
                        end else begin
                            hidx <= hidx + 1'b1;
                        end
                    end
                end
                default: begin
                    if (accept) begin
                        rem  <= rem - 1'b1;
                        lane <= lane + 1'b1;
                        if (rem == 16'd1) state <= TX_IDLE;
                    end
                end
            endcase
        end
    end
endmodule

// File: rtl/dsi_gcmd_rx.sv
module dsi_gcmd_rx (
    input  logic        clk,
    input  logic        rst,
    input  logic        rx_valid,
    input  logic [7:0]  rx_data,
    input  logic        rx_last,
    output logic        word_push,
    output logic [31:0] word_data
);
    logic [31:0] acc;
    logic [1:0]  idx;

    assign word_data = acc | (32'(rx_data) << {idx, 3'b000});
    assign word_push = rx_valid && (idx == 2'd3 || rx_last);

    always_ff @(posedge clk) begin
        if (rst) begin
            acc <= '0;
            idx <= '0;
        end else if (rx_valid) begin
            if (word_push) begin
                acc <= '0;
                idx <= '0;
            end else begin
                acc <= word_data;
                idx <= idx + 1'b1;
            end
        end
    end
endmodule

// File: rtl/dsi_gcmd_engine.sv
module dsi_gcmd_engine
    import dsi_gcmd_pkg::*;
#(
    parameter int CMD_DEPTH = 4,
    parameter int PLD_DEPTH = 8,
    parameter int RSP_DEPTH = 8
) (
    input  logic        clk,
    input  logic        rst,
    input  logic        hdr_wr_en,
    input  logic [23:0] hdr_wdata,
    input  logic        pld_wr_en,
    input  logic [31:0] pld_wdata,
    input  logic        pld_rd_en,
    output logic [31:0] pld_rdata,
    output logic [7:0]  status,
    output logic        cmd_ovf,
    output logic        tx_valid,
    input  logic        tx_ready,
    output logic [7:0]  tx_data,
    output logic        tx_sop,
    output logic        tx_last,
    input  logic        rx_valid,
    input  logic [7:0]  rx_data,
    input  logic        rx_last
);
    localparam int CCW = level_width(CMD_DEPTH);
    localparam int PCW = level_width(PLD_DEPTH);
    localparam int RCW = level_width(RSP_DEPTH);

    gcmd_hdr_t      hdr_in, cmd_head;
    logic [23:0]    cmd_rdata;
    logic [CCW-1:0] cmd_count;
    logic [PCW-1:0] pld_count;
    logic [RCW-1:0] rsp_count;
    logic           cmd_push, cmd_pop, cmd_full;
    logic           pld_pop;
    logic [31:0]    pld_word;
    logic           rsp_push;
    logic [31:0]    rsp_word;
    logic           rd_done;

    assign hdr_in   = gcmd_hdr_t'(hdr_wdata);
    assign cmd_head = gcmd_hdr_t'(cmd_rdata);
    assign cmd_push = hdr_wr_en && !dt_is_barred(hdr_in.dt);
    assign cmd_full = (cmd_count == CCW'(CMD_DEPTH));

    dsi_gcmd_fifo #(.W(24), .DEPTH(CMD_DEPTH)) u_cmd_q (
        .clk(clk), .rst(rst), .push(cmd_push), .wdata(hdr_in),
        .pop(cmd_pop), .rdata(cmd_rdata), .count(cmd_count)
    );

    dsi_gcmd_fifo #(.W(32), .DEPTH(PLD_DEPTH)) u_pld_q (
        .clk(clk), .rst(rst), .push(pld_wr_en), .wdata(pld_wdata),
        .pop(pld_pop), .rdata(pld_word), .count(pld_count)
    );

    dsi_gcmd_fifo #(.W(32), .DEPTH(RSP_DEPTH)) u_rsp_q (
        .clk(clk), .rst(rst), .push(rsp_push), .wdata(rsp_word),
        .pop(pld_rd_en), .rdata(pld_rdata), .count(rsp_count)
    );

    dsi_gcmd_tx #(.PCW(PCW)) u_tx (
        .clk(clk), .rst(rst),
        .cmd_valid(cmd_count != '0), .cmd_hdr(cmd_head), .cmd_pop(cmd_pop),
        .pld_word(pld_word), .pld_count(pld_count), .pld_pop(pld_pop),
        .tx_valid(tx_valid), .tx_ready(tx_ready), .tx_data(tx_data),
        .tx_sop(tx_sop), .tx_last(tx_last)
    );

    dsi_gcmd_rx u_rx (
        .clk(clk), .rst(rst), .rx_valid(rx_valid), .rx_data(rx_data),
        .rx_last(rx_last), .word_push(rsp_push), .word_data(rsp_word)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            cmd_ovf <= 1'b0;
            rd_done <= 1'b0;
        end else begin
            if (cmd_push && cmd_full) cmd_ovf <= 1'b1;
            if (rx_valid && rx_last)  rd_done <= 1'b1;
            else if (hdr_wr_en)       rd_done <= 1'b0;
        end
    end

    always_comb begin
        status               = '0;
        status[ST_RSP_EMPTY] = (rsp_count == '0);
        status[ST_PLD_EMPTY] = (pld_count == '0);
        status[ST_CMD_EMPTY] = (cmd_count == '0);
        status[ST_RD_DONE]   = rd_done;
    end
endmodule

// File: rtl/dsi_gcmd_engine_chk.sv
module dsi_gcmd_engine_chk (
    input logic        clk,
    input logic        rst,
    input logic        hdr_wr_en,
    input logic [23:0] hdr_wdata,
    input logic        cmd_full,
    input logic [7:0]  status,
    input logic        cmd_ovf,
    input logic        tx_valid,
    input logic        tx_ready,
    input logic [7:0]  tx_data,
    input logic        tx_sop,
    input logic        tx_last,
    input logic        rx_valid,
    input logic        rx_last
);
    p_ovf_set_r6: assert property (@(posedge clk) disable iff (rst)
        hdr_wr_en && cmd_full && hdr_wdata[5:0] != 6'h09 && hdr_wdata[5:0] != 6'h19
        |=> cmd_ovf);

    p_ovf_sticky_r6: assert property (@(posedge clk) disable iff (rst)
        cmd_ovf |=> cmd_ovf);

    p_done_set_r9: assert property (@(posedge clk) disable iff (rst)
        rx_valid && rx_last |=> status[7]);

    p_done_clear_r9: assert property (@(posedge clk) disable iff (rst)
        hdr_wr_en && !(rx_valid && rx_last) |=> !status[7]);

    p_tx_hold_r10: assert property (@(posedge clk) disable iff (rst)
        tx_valid && !tx_ready |=> tx_valid && $stable(tx_data) && $stable(tx_sop) && $stable(tx_last));

    p_no_barred_r5: assert property (@(posedge clk) disable iff (rst)
        tx_valid && tx_sop |-> tx_data[5:0] != 6'h09 && tx_data[5:0] != 6'h19);

    p_quiet_when_empty_r7: assert property (@(posedge clk) disable iff (rst)
        status[5] |-> !tx_valid);
endmodule

bind dsi_gcmd_engine dsi_gcmd_engine_chk u_chk (
    .clk(clk), .rst(rst), .hdr_wr_en(hdr_wr_en), .hdr_wdata(hdr_wdata),
    .cmd_full(cmd_full), .status(status), .cmd_ovf(cmd_ovf),
    .tx_valid(tx_valid), .tx_ready(tx_ready), .tx_data(tx_data),
    .tx_sop(tx_sop), .tx_last(tx_last), .rx_valid(rx_valid), .rx_last(rx_last)
);

// File: tb/dsi_gcmd_engine_tb.sv
module dsi_gcmd_engine_tb;
    logic        clk = 1'b0;
    logic        rst;
    logic        hdr_wr_en, pld_wr_en, pld_rd_en;
    logic [23:0] hdr_wdata;
    logic [31:0] pld_wdata, pld_rdata;
    logic [7:0]  status;
    logic        cmd_ovf, tx_valid, tx_sop, tx_last;
    logic        tx_ready = 1'b0;
    logic [7:0]  tx_data;
    logic        rx_valid, rx_last;
    logic [7:0]  rx_data;

    int checks   = 0;
    int failures = 0;
    int cyc      = 0;
    int rdy_mode = 0;
    logic [9:0] expq [$];
    logic [7:0] pay [16];

    always #10 clk = ~clk;

    dsi_gcmd_engine u_dut (
        .clk(clk), .rst(rst), .hdr_wr_en(hdr_wr_en), .hdr_wdata(hdr_wdata),
        .pld_wr_en(pld_wr_en), .pld_wdata(pld_wdata), .pld_rd_en(pld_rd_en),
        .pld_rdata(pld_rdata), .status(status), .cmd_ovf(cmd_ovf),
        .tx_valid(tx_valid), .tx_ready(tx_ready), .tx_data(tx_data),
        .tx_sop(tx_sop), .tx_last(tx_last), .rx_valid(rx_valid),
        .rx_data(rx_data), .rx_last(rx_last)
    );

    task automatic chk(input logic ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (!ok) begin
            failures++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    // Monitor: sets ready for the coming edge, then compares any byte that edge will take.
    always @(negedge clk) begin
        cyc++;
        case (rdy_mode)
            0:       tx_ready = 1'b1;
            1:       tx_ready = (cyc % 3 != 2);
            default: tx_ready = 1'b0;
        endcase
        if (!rst && tx_valid && tx_ready) begin
            if (expq.size() == 0) begin
                chk(1'b0, "R11 unexpected byte", {22'd0, tx_data, tx_sop, tx_last}, 32'h0);
            end else begin
                logic [9:0] e;
                e = expq.pop_front();
                chk({tx_data, tx_sop, tx_last} == e, "R1 R2 R3 R11 byte stream",
                    {22'd0, tx_data, tx_sop, tx_last}, {22'd0, e});
            end
        end
    end

    task automatic write_hdr(input logic [5:0] dt, input logic [1:0] vc,
                             input logic [7:0] lo, input logic [7:0] hi);
        @(negedge clk);
        hdr_wr_en = 1'b1;
        hdr_wdata = {hi, lo, vc, dt};
        @(negedge clk);
        hdr_wr_en = 1'b0;
    endtask

    task automatic write_word(input logic [31:0] w);
        @(negedge clk);
        pld_wr_en = 1'b1;
        pld_wdata = w;
        @(negedge clk);
        pld_wr_en = 1'b0;
    endtask

    task automatic expect_hdr(input logic [5:0] dt, input logic [1:0] vc,
                              input logic [7:0] lo, input logic [7:0] hi, input logic ends);
        expq.push_back({vc, dt, 1'b1, 1'b0});
        expq.push_back({lo, 1'b0, 1'b0});
        expq.push_back({hi, 1'b0, ends});
    endtask

    task automatic send_short(input logic [5:0] dt, input logic [1:0] vc,
                              input logic [7:0] lo, input logic [7:0] hi);
        expect_hdr(dt, vc, lo, hi, 1'b1);
        write_hdr(dt, vc, lo, hi);
    endtask

    // Payload words first (junk in unused upper bytes), then the header.
    task automatic send_long(input logic [5:0] dt, input logic [1:0] vc, input int n);
        for (int w = 0; w < (n + 3) / 4; w++) begin
            logic [31:0] word;
            word = 32'hEEEEEEEE;
            for (int b = 0; b < 4; b++)
                if (w * 4 + b < n) word[b*8 +: 8] = pay[w*4 + b];
            write_word(word);
        end
        expect_hdr(dt, vc, 8'(n), 8'(n >> 8), n == 0);
        for (int i = 0; i < n; i++) expq.push_back({pay[i], 1'b0, i == n - 1});
        write_hdr(dt, vc, 8'(n), 8'(n >> 8));
    endtask

    task automatic drain();
        int t = 0;
        while (expq.size() != 0 && t < 3000) begin
            @(negedge clk);
            t++;
        end
        chk(expq.size() == 0, "R11 drain", 32'(expq.size()), 32'd0);
        repeat (3) @(negedge clk);
    endtask

    task automatic rx_send(input int n);
        for (int i = 0; i < n; i++) begin
            @(negedge clk);
            rx_valid = 1'b1;
            rx_data  = pay[i];
            rx_last  = (i == n - 1);
        end
        @(negedge clk);
        rx_valid = 1'b0;
        rx_last  = 1'b0;
    endtask

    task automatic pop_rsp();
        pld_rd_en = 1'b1;
        @(negedge clk);
        pld_rd_en = 1'b0;
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        failures++;
        $display("FAIL watchdog expired");
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

    initial begin
        logic [7:0] held;
        rst = 1'b1;
        hdr_wr_en = 0; hdr_wdata = '0; pld_wr_en = 0; pld_wdata = '0; pld_rd_en = 0;
        rx_valid = 0; rx_data = '0; rx_last = 0;
        repeat (3) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        chk(status == 8'h2A, "R7 reset status", {24'd0, status}, 32'h2A);
        chk(cmd_ovf == 1'b0, "R6 reset overflow", {31'd0, cmd_ovf}, 0);
        chk(tx_valid == 1'b0, "R1 reset idle", {31'd0, tx_valid}, 0);

        // Short packets (R1, R2)
        send_short(6'h15, 2'd1, 8'h36, 8'h00);
        send_short(6'h23, 2'd3, 8'hAB, 8'hCD);
        drain();

        // Long packets with stalls (R3)
        rdy_mode = 1;
        for (int i = 0; i < 16; i++) pay[i] = 8'(8'h11 * (i + 1));
        send_long(6'h39, 2'd0, 6);
        send_long(6'h29, 2'd2, 5);
        send_long(6'h39, 2'd1, 4);
        send_long(6'h29, 2'd3, 0);
        drain();
        chk(status[3] == 1'b1, "R3 trimmed words consumed", {31'd0, status[3]}, 1);
        rdy_mode = 0;

        // Payload gate (R4)
        for (int i = 0; i < 7; i++) pay[i] = 8'(8'hA0 + i);
        expect_hdr(6'h29, 2'd0, 8'd7, 8'd0, 1'b0);
        for (int i = 0; i < 7; i++) expq.push_back({pay[i], 1'b0, i == 6});
        write_hdr(6'h29, 2'd0, 8'd7, 8'd0);
        repeat (20) @(negedge clk);
        chk(tx_valid == 1'b0, "R4 held without payload", {31'd0, tx_valid}, 0);
        chk(status[5] == 1'b0, "R4 command pending", {31'd0, status[5]}, 0);
        write_word({pay[3], pay[2], pay[1], pay[0]});
        repeat (10) @(negedge clk);
        chk(tx_valid == 1'b0, "R4 held with partial payload", {31'd0, tx_valid}, 0);
        write_word({8'hEE, pay[6], pay[5], pay[4]});
        drain();

        // Barred types (R5)
        write_hdr(6'h09, 2'd0, 8'h04, 8'h00);
        write_hdr(6'h19, 2'd1, 8'h00, 8'h00);
        repeat (10) @(negedge clk);
        chk(tx_valid == 1'b0, "R5 null/blanking not sent", {31'd0, tx_valid}, 0);
        chk(status[5] == 1'b1, "R5 command queue stays empty", {31'd0, status[5]}, 1);
        chk(cmd_ovf == 1'b0, "R5 no overflow", {31'd0, cmd_ovf}, 0);

        // Overflow and hold (R6, R10, R11)
        rdy_mode = 2;
        send_short(6'h03, 2'd0, 8'h01, 8'h00);
        send_short(6'h13, 2'd1, 8'h02, 8'h00);
        send_short(6'h23, 2'd2, 8'h03, 8'h04);
        send_short(6'h05, 2'd3, 8'h05, 8'h00);
        chk(cmd_ovf == 1'b0, "R6 no overflow at capacity", {31'd0, cmd_ovf}, 0);
        write_hdr(6'h15, 2'd0, 8'h06, 8'h00);
        chk(cmd_ovf == 1'b1, "R6 overflow set", {31'd0, cmd_ovf}, 1);
        held = tx_data;
        repeat (5) @(negedge clk);
        chk(tx_valid == 1'b1 && tx_data == held, "R10 byte held under back-pressure",
            {23'd0, tx_valid, tx_data}, {23'd0, 1'b1, held});
        rdy_mode = 0;
        drain();
        chk(cmd_ovf == 1'b1, "R6 overflow sticky", {31'd0, cmd_ovf}, 1);

        // Response packing (R8, R9)
        pay[0] = 8'hA1; pay[1] = 8'hB2; pay[2] = 8'hC3; pay[3] = 8'hD4; pay[4] = 8'hE5;
        rx_send(5);
        chk(status[7] == 1'b1, "R9 read done set", {31'd0, status[7]}, 1);
        chk(status[1] == 1'b0, "R7 response queue not empty", {31'd0, status[1]}, 0);
        chk(pld_rdata == 32'hD4C3B2A1, "R8 first word little-endian", pld_rdata, 32'hD4C3B2A1);
        pop_rsp();
        chk(pld_rdata == 32'h000000E5, "R8 partial word zero padded", pld_rdata, 32'h000000E5);
        pop_rsp();
        chk(status[1] == 1'b1, "R8 response queue empty after reads", {31'd0, status[1]}, 1);
        pay[0] = 8'h5A; pay[1] = 8'h6B;
        rx_send(2);
        chk(pld_rdata == 32'h00006B5A, "R8 two byte response", pld_rdata, 32'h00006B5A);
        pop_rsp();
        send_short(6'h05, 2'd0, 8'h0A, 8'h00);
        chk(status[7] == 1'b0, "R9 read done cleared by header write", {31'd0, status[7]}, 0);
        drain();
        chk(status == 8'h2A, "R7 idle status", {24'd0, status}, 32'h2A);

        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end
endmodule